// File: doc/BRIEF.md
# Epoch-Tagged Instruction Fetch Stage

This block is the front end of a four-stage in-order pipeline. It owns the program counter. Each cycle that it has room, it places the current address into a request queue and advances the counter by four. For every address it also writes the sequential return address (address plus four) into a separate return queue. Branch logic further down the pipeline uses that value. The request queue presents its head to an instruction memory that answers one cycle after it accepts a request, even on a hit. Answers land in a response queue. The heads of the response queue and the return queue together form the instruction handed to execute.

When execute finds that a branch went the wrong way, it asserts a redirect with the correct target. In that same cycle the block loads the target into the program counter and flips a one-bit epoch. Each return-queue entry records the epoch that was current when its address was fetched. A response whose paired entry carries an old epoch is therefore from the wrong path. Such an instruction is dropped at the queue heads without reaching execute. This covers requests that were still queued, requests already sent to memory, and replies that arrive after the redirect.

The design assumes that execute issues at most one redirect until it has received an instruction of the new epoch. With a single epoch bit, that spacing is what makes the wrong-path filter exact.

Top module: `fetch_epoch_stage`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, neither `imem_req_valid` nor `exe_valid` is high. The first address requested after reset is `RESET_PC`.
- R2: When not stalled, each cycle enqueues the current PC as a request and adds 4 to the PC. Requests go to memory in program order, and `imem_req_addr` stays unchanged while `imem_req_valid` is high and `imem_req_ready` is low.
- R3: A memory response is accepted only when a request is outstanding, so no response can arrive in the same cycle as its request. The fetch stage never issues more requests than the response queue can absorb.
- R4: Execute receives instructions in program order. Each one has `exe_inst` equal to the memory word at address A and `exe_pc4` equal to A+4. An offered instruction is held steady until `exe_ready` is high, unless a redirect intervenes.
- R5: A redirect loads `redirect_pc` into the PC and flips the epoch in the same cycle. The next address enqueued is `redirect_pc`, and the first instruction execute receives after the redirect has `exe_pc4` equal to `redirect_pc`+4.
- R6: No instruction fetched before a redirect reaches execute afterwards, whether it was still queued, in flight to memory, or already returned. Such instructions are discarded one per cycle even while `exe_ready` is low.
- R7: Fetch enqueues nothing while the request queue or the return queue is full. When memory back-pressure is released, fetching resumes at the next sequential address without skipping or repeating any address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_req_valid | output | 1 | A fetch address is offered to instruction memory |
| imem_req_addr | output | AW | Fetch address |
| imem_req_ready | input | 1 | Memory accepts the offered address this cycle |
| imem_resp_valid | input | 1 | Memory returns an instruction word |
| imem_resp_data | input | IW | Returned instruction word |
| exe_valid | output | 1 | A current-epoch instruction is offered to execute |
| exe_inst | output | IW | Instruction word for execute |
| exe_pc4 | output | AW | Return address (fetch address + 4) paired with the instruction |
| exe_ready | input | 1 | Execute takes the offered instruction |
| redirect_valid | input | 1 | Mispredict: restart fetch at `redirect_pc` |
| redirect_pc | input | AW | Correct target address |

## Verification
A redirect can land in the same cycle as other activity: a memory reply arriving, a fetch being enqueued with the old PC, and execute taking an instruction. The bench provokes this by pulsing the redirect while the pipeline streams at full rate. It also pulses the redirect when execute is blocked and every queue is full of wrong-path work. Each case is judged from the log of instructions execute received. Every entry after the redirect edge must continue from the target address with no gap. Entries from the old path must not reappear, including the one fetched in the redirect cycle itself. Memory back-pressure is checked the same way: the sequence must resume without a skipped or repeated address.

// File: rtl/fetch_epoch_stage.sv
module fetch_epoch_stage #(
  parameter int AW = 32,
  parameter int IW = 32,
  parameter int DEPTH = 2,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          imem_req_valid,
  output logic [AW-1:0] imem_req_addr,
  input  logic          imem_req_ready,
  input  logic          imem_resp_valid,
  input  logic [IW-1:0] imem_resp_data,
  output logic          exe_valid,
  output logic [IW-1:0] exe_inst,
  output logic [AW-1:0] exe_pc4,
  input  logic          exe_ready,
  input  logic          redirect_valid,
  input  logic [AW-1:0] redirect_pc
);
  localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW  = PW + 1;
  localparam int RAD = 2 * DEPTH;
  localparam int RPW = PW + 1;
  localparam int RCW = RPW + 1;

  logic [AW-1:0] pc;
  logic          epoch;

  logic [AW-1:0] rq_mem [DEPTH];
  logic [PW-1:0] rq_rd, rq_wr;
  logic [CW-1:0] rq_cnt;

  logic [IW-1:0] rsp_mem [DEPTH];
  logic [PW-1:0] rsp_rd, rsp_wr;
  logic [CW-1:0] rsp_cnt;

  logic [AW-1:0]  ra_pc [RAD];
  logic           ra_ep [RAD];
  logic [RPW-1:0] ra_rd, ra_wr;
  logic [RCW-1:0] ra_cnt;

  logic [CW-1:0] out_cnt;

  logic fetch_go, credit_ok, req_go, stale, rsp_any, rsp_pop;

  assign fetch_go  = (rq_cnt != CW'(DEPTH)) && (ra_cnt != RCW'(RAD));
  assign credit_ok = ({1'b0, out_cnt} + {1'b0, rsp_cnt}) < (CW+1)'(DEPTH);
  assign imem_req_valid = (rq_cnt != '0) && credit_ok;
  assign imem_req_addr  = rq_mem[rq_rd];
  assign req_go   = imem_req_valid && imem_req_ready;

  assign rsp_any   = rsp_cnt != '0;
  assign stale     = ra_ep[ra_rd] != epoch;
  assign exe_valid = rsp_any && !stale;
  assign exe_inst  = rsp_mem[rsp_rd];
  assign exe_pc4   = ra_pc[ra_rd];
  assign rsp_pop   = rsp_any && (stale || exe_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc      <= RESET_PC;
      epoch   <= 1'b0;
      rq_rd   <= '0;
      rq_wr   <= '0;
      rq_cnt  <= '0;
      rsp_rd  <= '0;
      rsp_wr  <= '0;
      rsp_cnt <= '0;
      ra_rd   <= '0;
      ra_wr   <= '0;
      ra_cnt  <= '0;
      out_cnt <= '0;
    end else begin
      if (redirect_valid) begin
        pc    <= redirect_pc;
        epoch <= ~epoch;
      end else if (fetch_go) begin
        pc <= pc + AW'(4);
      end
      if (fetch_go) begin
        rq_wr <= rq_wr + 1'b1;
        ra_wr <= ra_wr + 1'b1;
      end
      if (req_go)          rq_rd  <= rq_rd + 1'b1;
      if (imem_resp_valid) rsp_wr <= rsp_wr + 1'b1;
      if (rsp_pop) begin
        rsp_rd <= rsp_rd + 1'b1;
        ra_rd  <= ra_rd + 1'b1;
      end
      rq_cnt  <= rq_cnt + CW'(fetch_go) - CW'(req_go);
      ra_cnt  <= ra_cnt + RCW'(fetch_go) - RCW'(rsp_pop);
      rsp_cnt <= rsp_cnt + CW'(imem_resp_valid) - CW'(rsp_pop);
      out_cnt <= out_cnt + CW'(req_go) - CW'(imem_resp_valid);
    end
  end

  always_ff @(posedge clk) begin
    if (fetch_go) begin
      rq_mem[rq_wr] <= pc;
      ra_pc[ra_wr]  <= pc + AW'(4);
      ra_ep[ra_wr]  <= epoch;
    end
    if (imem_resp_valid) rsp_mem[rsp_wr] <= imem_resp_data;
  end
endmodule

module fetch_epoch_chk #(
  parameter int AW = 32,
  parameter int DEPTH = 2,
  parameter int CW = 2,
  parameter int RCW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           imem_req_valid,
  input logic           imem_req_ready,
  input logic [AW-1:0]  imem_req_addr,
  input logic           imem_resp_valid,
  input logic           exe_valid,
  input logic           exe_ready,
  input logic [AW-1:0]  exe_pc4,
  input logic           redirect_valid,
  input logic [AW-1:0]  redirect_pc,
  input logic [AW-1:0]  pc,
  input logic           epoch,
  input logic [CW-1:0]  rq_cnt,
  input logic [CW-1:0]  rsp_cnt,
  input logic [CW-1:0]  out_cnt,
  input logic [RCW-1:0] ra_cnt
);
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    imem_req_valid && !imem_req_ready |=> imem_req_valid && $stable(imem_req_addr));

  // R3
  resp_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    imem_resp_valid |-> out_cnt != '0);

  // R3
  credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, out_cnt} + {1'b0, rsp_cnt}) <= (CW+1)'(DEPTH));

  // R4
  exe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exe_valid && !exe_ready && !redirect_valid |=> exe_valid && $stable(exe_pc4));

  // R5
  redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> pc == $past(redirect_pc) && epoch != $past(epoch));

  // R6
  pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_cnt != '0 |-> ra_cnt >= RCW'(rsp_cnt));

  // R7
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect_valid && rq_cnt == CW'(DEPTH) |=> $stable(pc));
endmodule

bind fetch_epoch_stage fetch_epoch_chk #(.AW(AW), .DEPTH(DEPTH), .CW(CW), .RCW(RCW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .imem_req_valid(imem_req_valid), .imem_req_ready(imem_req_ready),
  .imem_req_addr(imem_req_addr), .imem_resp_valid(imem_resp_valid),
  .exe_valid(exe_valid), .exe_ready(exe_ready), .exe_pc4(exe_pc4),
  .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
  .pc(pc), .epoch(epoch), .rq_cnt(rq_cnt), .rsp_cnt(rsp_cnt),
  .out_cnt(out_cnt), .ra_cnt(ra_cnt)
);

// File: tb/tb_fetch_epoch_stage.sv
module tb_fetch_epoch_stage;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int IW = 32;
  localparam logic [AW-1:0] RPC = 32'h0000_0100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          imem_req_valid;
  logic [AW-1:0] imem_req_addr;
  logic          mem_ready = 1'b1;
  logic          imem_resp_valid;
  logic [IW-1:0] imem_resp_data;
  logic          exe_valid;
  logic [IW-1:0] exe_inst;
  logic [AW-1:0] exe_pc4;
  logic          exe_ready = 1'b1;
  logic          redirect_valid = 1'b0;
  logic [AW-1:0] redirect_pc = '0;

  int n_chk = 0;
  int n_fail = 0;
  logic [AW-1:0] log_pc [0:1023];
  logic [IW-1:0] log_in [0:1023];
  int n_log = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_epoch_stage #(.AW(AW), .IW(IW), .DEPTH(2), .RESET_PC(RPC)) dut (
    .clk(clk), .rst_n(rst_n),
    .imem_req_valid(imem_req_valid), .imem_req_addr(imem_req_addr),
    .imem_req_ready(mem_ready),
    .imem_resp_valid(imem_resp_valid), .imem_resp_data(imem_resp_data),
    .exe_valid(exe_valid), .exe_inst(exe_inst), .exe_pc4(exe_pc4),
    .exe_ready(exe_ready),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
  );

  function automatic logic [IW-1:0] word_at(logic [AW-1:0] a);
    return {~a[15:0], a[15:0]} ^ 32'h3C00_0000;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      imem_resp_valid <= 1'b0;
      imem_resp_data  <= '0;
    end else begin
      imem_resp_valid <= imem_req_valid && mem_ready;
      imem_resp_data  <= word_at(imem_req_addr);
    end
  end

  always @(posedge clk) begin
    if (rst_n && exe_valid && exe_ready && n_log < 1024) begin
      log_pc[n_log] <= exe_pc4;
      log_in[n_log] <= exe_inst;
      n_log <= n_log + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_run(input int base, input int cnt, input logic [AW-1:0] start, input string req);
    chk(n_log - base >= cnt, req, "delivered count", n_log - base, cnt);
    for (int i = 0; i < cnt; i++) begin
      chk(log_pc[base+i] == start + AW'(4*(i+1)), req, "exe_pc4", log_pc[base+i], start + AW'(4*(i+1)));
      chk(log_in[base+i] == word_at(start + AW'(4*i)), req, "exe_inst", log_in[base+i], word_at(start + AW'(4*i)));
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    cycles(3);
    chk(imem_req_valid == 1'b0, "R1", "req_valid in reset", imem_req_valid, 0);
    chk(exe_valid == 1'b0, "R1", "exe_valid in reset", exe_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(imem_req_valid == 1'b1, "R2", "first request offered", imem_req_valid, 1);
    chk(imem_req_addr == RPC, "R1", "first address", imem_req_addr, RPC);
    chk(exe_valid == 1'b0, "R3", "no same-cycle response", exe_valid, 0);
  endtask

  task automatic t_stream;
    cycles(14);
    check_run(0, 8, RPC, "R4");
  endtask

  task automatic t_redirect_run;
    int base;
    logic [AW-1:0] tgt = 32'h0000_1000;
    redirect_valid = 1'b1;
    redirect_pc = tgt;
    @(negedge clk);
    redirect_valid = 1'b0;
    base = n_log;
    cycles(16);
    check_run(base, 6, tgt, "R5");
  endtask

  task automatic t_redirect_blocked;
    int base;
    logic [AW-1:0] tgt = 32'h0000_2000;
    logic [AW-1:0] held;
    exe_ready = 1'b0;
    cycles(10);
    held = exe_pc4;
    chk(exe_valid == 1'b1, "R4", "offer while blocked", exe_valid, 1);
    cycles(2);
    chk(exe_pc4 == held, "R4", "offer held while blocked", exe_pc4, held);
    redirect_valid = 1'b1;
    redirect_pc = tgt;
    @(negedge clk);
    redirect_valid = 1'b0;
    base = n_log;
    cycles(12);
    chk(exe_valid == 1'b1, "R6", "stale drained without ready", exe_valid, 1);
    chk(exe_pc4 == tgt + 32'd4, "R6", "first offer after drain", exe_pc4, tgt + 32'd4);
    exe_ready = 1'b1;
    cycles(16);
    check_run(base, 6, tgt, "R6");
  endtask

  task automatic t_backpressure;
    int base;
    logic [AW-1:0] held;
    mem_ready = 1'b0;
    @(negedge clk);
    held = imem_req_addr;
    cycles(20);
    chk(imem_req_valid == 1'b1, "R2", "request held valid", imem_req_valid, 1);
    chk(imem_req_addr == held, "R2", "request address held", imem_req_addr, held);
    chk(exe_valid == 1'b0, "R7", "nothing offered under stall", exe_valid, 0);
    base = n_log;
    mem_ready = 1'b1;
    cycles(20);
    check_run(base, 8, log_pc[base-1], "R7");
  endtask

  initial begin
    t_reset();
    t_stream();
    t_redirect_run();
    t_redirect_blocked();
    t_backpressure();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule